// File: doc/BRIEF.md
# Result Routing and Method Send Unit

This unit sits behind a small command processor's arithmetic stage. Each computed result arrives with a destination register index and a 3-bit routing code. The code selects what happens next: a register write, a fetch of the next word from an in-order parameter stream, a load of the method address register, and an (address, value) send transaction to a downstream engine. These actions are combined and ordered in eight fixed ways.

The method address register is 18 bits wide. The low 12 bits are the target address. The upper 6 bits are a step that is added to the address after every send, so a burst of sends walks through consecutive or strided targets without reloading. A start pulse begins a program: the method register is cleared and the first parameter word is written to register 1. The unit stalls on an empty parameter stream and holds a send until the engine accepts it. It pulses `done` once a result's work is complete.

Top module: `res_route_unit`

## Requirements
- R1: The routing code `res_mode` selects where the register write takes its data. Codes 0 (fetch to register), 3 (fetch and send) and 5 (fetch and set method) write the fetched parameter word to `res_dst`. Codes 1 (move), 2 (move and set method), 4 (move and send), 6 (move, set method, send fetched word) and 7 (move, set method, send step field) write `res_value` to `res_dst`.
- R2: A register write aimed at index 0 never appears on the write port.
- R3: Codes 0, 3, 5 and 6 consume exactly one word from the parameter stream, in order. The other codes consume none.
- R4: Codes 2, 5, 6 and 7 load the method register from `res_value[17:0]`. In that register, bits 11:0 are the address and bits 17:12 are the step.
- R5: The send data depends on the code. Codes 3 and 4 send `res_value`. Code 6 sends the fetched word. Code 7 sends `res_value[17:12]` zero-extended. The send address is method bits 11:0. When a code both loads the method register and sends, the new value is loaded before the send is issued.
- R6: After each accepted send, the address advances by the step, modulo 4096, and the step is kept. A zero step leaves the address unchanged.
- R7: A `start` pulse clears the method register and writes the next parameter word to register 1.
- R8: `par_ready` waits as long as the stream is empty. `snd_valid` stays high with stable address and data until `snd_ready`.
- R9: `done` is a single-cycle pulse that follows the last write, fetch or send of a result. `res_ready` is high only while the unit is idle and `start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Program start: clear method, fetch word into register 1 |
| res_valid | input | 1 | Result offered |
| res_ready | output | 1 | Result accepted this cycle when valid |
| res_mode | input | 3 | Routing code |
| res_value | input | 32 | Computed result |
| res_dst | input | 3 | Destination register index |
| par_valid | input | 1 | Parameter word available |
| par_ready | output | 1 | Parameter word consumed when valid |
| par_data | input | 32 | Parameter word |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 3 | Register write index |
| wr_data | output | 32 | Register write data |
| snd_valid | output | 1 | Send transaction offered |
| snd_ready | input | 1 | Downstream accepts send |
| snd_addr | output | 12 | Send target address |
| snd_data | output | 32 | Send value |
| done | output | 1 | Result handling finished |

## Verification
The bench sweeps every routing code against destinations including index 0, with varied stream and send back-pressure. It checks register, fetch and send outcomes against a model of the method register.

Several corner cases are targeted directly:
- An address loaded at 0xFF0 with step 0x20 must wrap to 0x010. A design that carries into the step field would corrupt the next target.
- A zero step must repeat the same address.
- Code 6 must send the fetched word, not the result. Code 7 must send the step field, not the address.
- A design that sends before loading the method register would show the stale address.
- A design that writes register 0, or fetches in move-only codes, would skew every later parameter.

// File: rtl/rr_pkg.sv
package rr_pkg;

    typedef enum logic [2:0] {
        MODE_FETCH_WR      = 3'd0,
        MODE_MOVE          = 3'd1,
        MODE_MOVE_SETM     = 3'd2,
        MODE_FETCH_SEND    = 3'd3,
        MODE_MOVE_SEND     = 3'd4,
        MODE_FETCH_SETM    = 3'd5,
        MODE_SETM_FSEND    = 3'd6,
        MODE_SETM_STEPSEND = 3'd7
    } res_mode_e;

    typedef enum logic [1:0] {
        SRC_RESULT,
        SRC_FETCH,
        SRC_STEP
    } send_src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEND
    } seq_state_e;

    typedef struct packed {
        logic      wr_from_result;
        logic      wr_from_fetch;
        logic      need_fetch;
        logic      set_method;
        logic      send;
        send_src_e send_src;
    } route_plan_t;

    function automatic route_plan_t plan_for(res_mode_e m);
        route_plan_t p;
        p = '{wr_from_result: 1'b0, wr_from_fetch: 1'b0, need_fetch: 1'b0,
              set_method: 1'b0, send: 1'b0, send_src: SRC_RESULT};
        unique case (m)
            MODE_FETCH_WR: begin
                p.wr_from_fetch = 1'b1; p.need_fetch = 1'b1;
            end
            MODE_MOVE: begin
                p.wr_from_result = 1'b1;
            end
            MODE_MOVE_SETM: begin
                p.wr_from_result = 1'b1; p.set_method = 1'b1;
            end
            MODE_FETCH_SEND: begin
                p.wr_from_fetch = 1'b1; p.need_fetch = 1'b1; p.send = 1'b1;
            end
            MODE_MOVE_SEND: begin
                p.wr_from_result = 1'b1; p.send = 1'b1;
            end
            MODE_FETCH_SETM: begin
                p.wr_from_fetch = 1'b1; p.need_fetch = 1'b1; p.set_method = 1'b1;
            end
            MODE_SETM_FSEND: begin
                p.wr_from_result = 1'b1; p.set_method = 1'b1; p.need_fetch = 1'b1;
                p.send = 1'b1; p.send_src = SRC_FETCH;
            end
            MODE_SETM_STEPSEND: begin
                p.wr_from_result = 1'b1; p.set_method = 1'b1;
                p.send = 1'b1; p.send_src = SRC_STEP;
            end
            default: ;
        endcase
        return p;
    endfunction

    function automatic route_plan_t plan_for_start();
        route_plan_t p;
        p = '{wr_from_result: 1'b0, wr_from_fetch: 1'b1, need_fetch: 1'b1,
              set_method: 1'b0, send: 1'b0, send_src: SRC_RESULT};
        return p;
    endfunction

endpackage

// File: rtl/rr_decode.sv
module rr_decode
    import rr_pkg::*;
(
    input  logic [2:0]  mode,
    output route_plan_t plan
);
    always_comb plan = plan_for(res_mode_e'(mode));
endmodule

// File: rtl/rr_method_reg.sv
module rr_method_reg #(
    parameter int ADDR_W = 12,
    parameter int STEP_W = 6,
    localparam int FIELD_W = ADDR_W + STEP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               load,
    input  logic [FIELD_W-1:0] load_val,
    input  logic               step,
    output logic [ADDR_W-1:0]  addr
);
    logic [STEP_W-1:0] stride;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            addr   <= '0;
            stride <= '0;
        end else if (load) begin
            addr   <= load_val[ADDR_W-1:0];
            stride <= load_val[FIELD_W-1:ADDR_W];
        end else if (step && (stride != '0)) begin
            addr   <= addr + ADDR_W'(stride);
        end
    end
endmodule

// File: rtl/rr_seq.sv
module rr_seq
    import rr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 12,
    parameter int STEP_W = 6,
    localparam int FIELD_W = ADDR_W + STEP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               res_valid,
    output logic               res_ready,
    input  route_plan_t        plan,
    input  logic [DATA_W-1:0]  res_value,
    input  logic [IDX_W-1:0]   res_dst,
    input  logic               par_valid,
    output logic               par_ready,
    input  logic [DATA_W-1:0]  par_data,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [DATA_W-1:0]  wr_data,
    output logic               snd_valid,
    input  logic               snd_ready,
    output logic [DATA_W-1:0]  snd_data,
    output logic               done,
    output logic               m_clear,
    output logic               m_load,
    output logic [FIELD_W-1:0] m_load_val,
    output logic               m_step
);
    seq_state_e        state;
    route_plan_t       cur_plan;
    logic [IDX_W-1:0]  cur_dst;
    logic [DATA_W-1:0] cur_value;
    logic              accept;
    logic              got_word;
    logic [DATA_W-1:0] step_word;

    assign res_ready  = (state == ST_IDLE) && !start;
    assign accept     = res_ready && res_valid;
    assign par_ready  = (state == ST_FETCH);
    assign got_word   = par_ready && par_valid;
    assign snd_valid  = (state == ST_SEND);
    assign m_clear    = (state == ST_IDLE) && start;
    assign m_load     = accept && plan.set_method;
    assign m_load_val = res_value[FIELD_W-1:0];
    assign m_step     = snd_valid && snd_ready;
    assign step_word  = {{(DATA_W-STEP_W){1'b0}}, res_value[FIELD_W-1:ADDR_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_plan  <= '0;
            cur_dst   <= '0;
            cur_value <= '0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
            snd_data  <= '0;
            done      <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            done  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur_plan <= plan_for_start();
                        cur_dst  <= IDX_W'(1);
                        state    <= ST_FETCH;
                    end else if (accept) begin
                        cur_plan  <= plan;
                        cur_dst   <= res_dst;
                        cur_value <= res_value;
                        if (plan.wr_from_result && (res_dst != '0)) begin
                            wr_en   <= 1'b1;
                            wr_idx  <= res_dst;
                            wr_data <= res_value;
                        end
                        snd_data <= (plan.send_src == SRC_STEP) ? step_word : res_value;
                        if (plan.need_fetch)
                            state <= ST_FETCH;
                        else if (plan.send)
                            state <= ST_SEND;
                        else
                            done <= 1'b1;
                    end
                end
                ST_FETCH: begin
                    if (got_word) begin
                        if (cur_plan.wr_from_fetch && (cur_dst != '0)) begin
                            wr_en   <= 1'b1;
                            wr_idx  <= cur_dst;
                            wr_data <= par_data;
                        end
                        if (cur_plan.send) begin
                            snd_data <= (cur_plan.send_src == SRC_FETCH) ? par_data : cur_value;
                            state    <= ST_SEND;
                        end else begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_SEND: begin
                    if (snd_ready) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/res_route_unit.sv
module res_route_unit
    import rr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 12,
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              res_valid,
    output logic              res_ready,
    input  logic [2:0]        res_mode,
    input  logic [DATA_W-1:0] res_value,
    input  logic [IDX_W-1:0]  res_dst,
    input  logic              par_valid,
    output logic              par_ready,
    input  logic [DATA_W-1:0] par_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              snd_valid,
    input  logic              snd_ready,
    output logic [ADDR_W-1:0] snd_addr,
    output logic [DATA_W-1:0] snd_data,
    output logic              done
);
    localparam int FIELD_W = ADDR_W + STEP_W;

    route_plan_t        plan;
    logic               m_clear;
    logic               m_load;
    logic [FIELD_W-1:0] m_load_val;
    logic               m_step;

    rr_decode u_dec (
        .mode (res_mode),
        .plan (plan)
    );

    rr_method_reg #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_mreg (
        .clk      (clk),
        .rst      (rst),
        .clear    (m_clear),
        .load     (m_load),
        .load_val (m_load_val),
        .step     (m_step),
        .addr     (snd_addr)
    );

    rr_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .res_valid  (res_valid),
        .res_ready  (res_ready),
        .plan       (plan),
        .res_value  (res_value),
        .res_dst    (res_dst),
        .par_valid  (par_valid),
        .par_ready  (par_ready),
        .par_data   (par_data),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .snd_valid  (snd_valid),
        .snd_ready  (snd_ready),
        .snd_data   (snd_data),
        .done       (done),
        .m_clear    (m_clear),
        .m_load     (m_load),
        .m_load_val (m_load_val),
        .m_step     (m_step)
    );
endmodule

// File: rtl/rr_route_chk.sv
module rr_route_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              res_ready,
    input logic              par_ready,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic              snd_valid,
    input logic              snd_ready,
    input logic [ADDR_W-1:0] snd_addr,
    input logic [DATA_W-1:0] snd_data,
    input logic              done
);
    // R2
    no_zero_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx != '0));

    // R8
    snd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (snd_valid && !snd_ready) |=> (snd_valid && $stable(snd_addr) && $stable(snd_data)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        res_ready |-> (!snd_valid && !par_ready));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    fetch_send_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(par_ready && snd_valid));
endmodule

bind res_route_unit rr_route_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .res_ready (res_ready),
    .par_ready (par_ready),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .snd_valid (snd_valid),
    .snd_ready (snd_ready),
    .snd_addr  (snd_addr),
    .snd_data  (snd_data),
    .done      (done)
);

// File: tb/tb_res_route_unit.sv
module tb_res_route_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        res_valid = 1'b0;
    logic        res_ready;
    logic [2:0]  res_mode = '0;
    logic [31:0] res_value = '0;
    logic [2:0]  res_dst = '0;
    logic        par_valid = 1'b0;
    logic        par_ready;
    logic [31:0] par_data = '0;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [31:0] wr_data;
    logic        snd_valid;
    logic        snd_ready = 1'b0;
    logic [11:0] snd_addr;
    logic [31:0] snd_data;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [11:0] m_addr = '0;
    logic [5:0]  m_step = '0;

    res_route_unit dut (.*);

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input bit is_start, input logic [2:0] mode, input logic [31:0] val,
                           input logic [2:0] dst, input logic [31:0] pword,
                           input int pd, input int sd);
        bit exp_fetch, exp_wr, exp_snd, setm;
        logic [31:0] exp_wdata, exp_sdata;
        logic [2:0]  exp_widx;
        logic [11:0] exp_saddr;
        int n_wr, n_snd, n_fetch;
        bit seen_done, fetched;
        logic [2:0]  got_idx;
        logic [31:0] got_wdata, got_sdata;
        logic [11:0] got_saddr;
        n_wr = 0; n_snd = 0; n_fetch = 0; seen_done = 0; fetched = 0;
        got_idx = '0; got_wdata = '0; got_sdata = '0; got_saddr = '0;
        // expected, from the requirement text
        if (is_start) begin
            exp_fetch = 1; exp_wr = 1; exp_widx = 3'd1; exp_wdata = pword;
            exp_snd = 0; exp_sdata = '0; setm = 0;
            m_addr = '0; m_step = '0;
        end else begin
            exp_fetch = (mode == 0) || (mode == 3) || (mode == 5) || (mode == 6);
            exp_wdata = ((mode == 0) || (mode == 3) || (mode == 5)) ? pword : val;
            exp_widx  = dst;
            exp_wr    = (dst != 0);
            setm      = (mode == 2) || (mode == 5) || (mode == 6) || (mode == 7);
            exp_snd   = (mode == 3) || (mode == 4) || (mode == 6) || (mode == 7);
            exp_sdata = (mode == 6) ? pword : (mode == 7) ? {26'd0, val[17:12]} : val;
            if (setm) begin
                m_addr = val[11:0]; m_step = val[17:12];
            end
        end
        exp_saddr = m_addr;
        @(negedge clk);
        chk("R9 res_ready idle", {31'd0, res_ready}, 32'd1);
        if (is_start) start = 1'b1;
        else begin
            res_valid = 1'b1; res_mode = mode; res_value = val; res_dst = dst;
        end
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            start = 1'b0; res_valid = 1'b0;
            if (wr_en) begin
                n_wr++; got_idx = wr_idx; got_wdata = wr_data;
            end
            if (done) begin
                seen_done = 1;
                break;
            end
            par_valid = (c >= pd) && !fetched;
            par_data  = pword;
            if (par_ready && par_valid) begin
                fetched = 1; n_fetch++;
            end
            snd_ready = (c >= sd);
            if (snd_valid && snd_ready) begin
                n_snd++; got_saddr = snd_addr; got_sdata = snd_data;
            end
        end
        par_valid = 1'b0; snd_ready = 1'b0;
        chk("R9 done pulse", {31'd0, seen_done}, 32'd1);
        chk("R3 fetch count", n_fetch, {31'd0, exp_fetch});
        chk(exp_wr ? "R1 write count" : "R2 write to zero dropped", n_wr, {31'd0, exp_wr});
        if (exp_wr && n_wr == 1) begin
            chk(is_start ? "R7 start write index" : "R1 write index", {29'd0, got_idx}, {29'd0, exp_widx});
            chk(is_start ? "R7 start write data" : "R1 write data", got_wdata, exp_wdata);
        end
        chk("R8 send count", n_snd, {31'd0, exp_snd});
        if (exp_snd && n_snd == 1) begin
            chk(setm ? "R4 loaded send address" : "R6 send address", {20'd0, got_saddr}, {20'd0, exp_saddr});
            chk("R5 send data", got_sdata, exp_sdata);
            m_addr = (m_addr + {6'd0, m_step}) & 12'hFFF;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset res_ready", {31'd0, res_ready}, 32'd1);
        chk("R9 reset wr_en", {31'd0, wr_en}, 32'd0);
        chk("R8 reset snd_valid", {31'd0, snd_valid}, 32'd0);
        chk("R3 reset par_ready", {31'd0, par_ready}, 32'd0);
        chk("R9 reset done", {31'd0, done}, 32'd0);

        // R7: start writes register 1 and clears the method address
        run_txn(1, 0, 0, 0, 32'hCAFE0001, 1, 0);
        run_txn(0, 3'd4, 32'h1234_5678, 3'd2, 32'h0, 0, 0);

        // sweep all codes over destinations and back-pressure
        for (int k = 0; k < 64; k++) begin
            logic [2:0]  md;
            logic [2:0]  ds;
            logic [31:0] v;
            md = 3'(k % 8);
            ds = 3'((k / 8) % 8);
            if ((k / 8) % 3 == 0) ds = 3'd0;
            v  = (32'h9E37_79B9 * (k + 1)) ^ (32'h0001_1000 * k);
            run_txn(0, md, v, ds, 32'h5000_0000 + 32'(k * 7), k % 3, (k / 3) % 3);
        end

        // R6: wrap at 4096 with step 0x20
        run_txn(0, 3'd2, 32'h0002_0FF0, 3'd2, 32'h0, 0, 0);
        run_txn(0, 3'd4, 32'hAAAA_0001, 3'd3, 32'h0, 0, 2);
        run_txn(0, 3'd4, 32'hAAAA_0002, 3'd3, 32'h0, 0, 0);
        // R6: zero step repeats the address
        run_txn(0, 3'd2, 32'h0000_0123, 3'd4, 32'h0, 0, 0);
        run_txn(0, 3'd3, 32'h0BAD_0001, 3'd5, 32'h7777, 2, 1);
        run_txn(0, 3'd4, 32'h0BAD_0002, 3'd5, 32'h0, 0, 0);
        // R5: step field send, and fetched-word send after load
        run_txn(0, 3'd7, 32'h0003_F5A5, 3'd6, 32'h0, 0, 3);
        run_txn(0, 3'd6, 32'h0001_0400, 3'd7, 32'hFEED_F00D, 3, 2);
        run_txn(0, 3'd4, 32'h0, 3'd0, 32'h0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule